// File: doc/BRIEF.md
# Byte/Word Data Memory Access Unit

This unit connects a 16-bit processor datapath to a data RAM that is organised in words. It handles both byte and word loads and stores. The RAM is built as two byte-wide banks. Both banks use one word index, but each has its own write enable, so a byte store changes only one lane and a word store changes both. Loads always fetch the whole word. For a byte load, the unit picks the lane that address bit 0 points to and moves it onto the low eight bits. It then builds the value to write back to the destination register. That value can keep the register's upper byte, sign-extend the byte, or zero-extend it.

A word access at an odd address is not split into two accesses. Instead it raises a one-cycle address-error pulse. A misaligned load still returns its data. A misaligned store writes nothing. When post-increment is requested, the unit also returns the next pointer value. It does this on faulting accesses too, so the state before the fault can be inspected afterwards.

Top module: `lane_access_unit`

## Requirements
- R1: `ptr_next` equals `ea + 1` for a byte access and `ea + 2` for a word access when `post_inc` is high and a read or write is requested. Otherwise it equals `ea`. This holds whether or not the access is misaligned.
- R2: A word store at an even address asserts `lane_we = 2'b11` in the same cycle. `wr_data[7:0]` is stored in the even bank (`lane_we[0]`) and `wr_data[15:8]` in the odd bank (`lane_we[1]`).
- R3: A byte store asserts only the lane selected by `ea[0]` (0 gives `2'b01`, 1 gives `2'b10`) and writes `wr_data[7:0]` there. The other bank keeps its contents, and `wr_data[15:8]` is ignored.
- R4: `rd_data` is updated on the clock edge that samples `rd_en`. It is taken from the word at index `ea[IDX_W:1]`, and it holds its value while `rd_en` is low.
- R5: A byte load places the byte selected by `ea[0]` (0 = bits [7:0], 1 = bits [15:8] of the word) on `rd_data[7:0]` and drives `rd_data[15:8]` to zero.
- R6: With `ext_mode = 0` (merge), the byte-load write-back `wb_data` is `{dst_in[15:8], byte}`. `dst_in` is sampled together with the load. `ext_mode = 3` behaves as merge.
- R7: With `ext_mode = 1`, `wb_data[15:8]` copies bit 7 of the loaded byte. With `ext_mode = 2`, `wb_data[15:8]` is zero. For a word load, `wb_data` equals the loaded word.
- R8: A word access with `ea[0] = 1` sets `addr_trap` high for exactly the cycle after the edge that samples it. A byte access never raises `addr_trap`, for either address parity.
- R9: A misaligned word load still completes and returns the word at index `ea[IDX_W:1]` on `rd_data` and `wb_data`.
- R10: A misaligned word store drives `lane_we = 2'b00`, and the RAM keeps its previous contents.
- R11: Synchronous reset clears `rd_data`, `wb_data` and `addr_trap` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ea | input | ADDR_W | Effective byte address |
| is_byte | input | 1 | Access size: 1 = byte, 0 = word |
| rd_en | input | 1 | Load request |
| wr_en | input | 1 | Store request |
| post_inc | input | 1 | Request for the incremented pointer |
| ext_mode | input | 2 | Byte-load write-back: 0 merge, 1 sign-extend, 2 zero-extend, 3 merge |
| wr_data | input | 16 | Store data |
| dst_in | input | 16 | Current destination register value |
| rd_data | output | 16 | Loaded data aligned to the low lane |
| wb_data | output | 16 | Register write-back value |
| lane_we | output | 2 | Bank write enables, bit 0 even bank, bit 1 odd bank |
| ptr_next | output | ADDR_W | Updated address pointer |
| addr_trap | output | 1 | Address-error pulse |

## Verification
`lane_we` and `ptr_next` depend only on the current request. The bench samples them one nanosecond after driving the inputs, which is still before the rising edge. `rd_data`, `wb_data` and `addr_trap` pass through one register stage, so the bench samples them two nanoseconds after the edge that takes the request, and before the next request is driven. The vector after each faulting access checks that `addr_trap` has fallen again. Reads placed after suppressed or partial stores show whether each bank kept or changed its contents.

// File: rtl/lane_access_pkg.sv
package lane_access_pkg;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        EXT_MERGE = 2'd0,
        EXT_SIGN  = 2'd1,
        EXT_ZERO  = 2'd2,
        EXT_RSVD  = 2'd3
    } ext_mode_e;

    // Context captured with a load, consumed one cycle later
    typedef struct packed {
        logic               is_byte;
        logic               hi_lane;
        ext_mode_e          ext;
        logic [BYTE_W-1:0]  keep_hi;
    } load_ctx_t;

    // Store request toward the banks
    typedef struct packed {
        logic [1:0]         we;
        logic [WORD_W-1:0]  lane_data;
    } store_req_t;

    function automatic logic [1:0] ptr_step(input logic is_byte);
        return is_byte ? 2'd1 : 2'd2;
    endfunction

    function automatic logic [WORD_W-1:0] widen_byte(
        input logic [BYTE_W-1:0] b,
        input logic [BYTE_W-1:0] keep_hi,
        input ext_mode_e         m
    );
        logic [WORD_W-1:0] r;
        case (m)
            EXT_SIGN: r = {{BYTE_W{b[BYTE_W-1]}}, b};
            EXT_ZERO: r = {{BYTE_W{1'b0}}, b};
            default:  r = {keep_hi, b};
        endcase
        return r;
    endfunction
endpackage

// File: rtl/lane_decode.sv
module lane_decode
    import lane_access_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] ea,
    input  logic              is_byte,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic              post_inc,
    input  logic [WORD_W-1:0] wr_data,
    output store_req_t        store,
    output logic              misalign,
    output logic [ADDR_W-1:0] ptr_next
);
    logic       access;
    logic [1:0] step;

    assign access   = rd_en | wr_en;
    assign misalign = access & ~is_byte & ea[0];

    always_comb begin
        store.we        = 2'b00;
        store.lane_data = wr_data;
        if (wr_en && !misalign) begin
            if (is_byte) begin
                store.we        = ea[0] ? 2'b10 : 2'b01;
                store.lane_data = {wr_data[BYTE_W-1:0], wr_data[BYTE_W-1:0]};
            end else begin
                store.we        = 2'b11;
            end
        end
    end

    assign step     = (access && post_inc) ? ptr_step(is_byte) : 2'd0;
    assign ptr_next = ea + {{(ADDR_W-2){1'b0}}, step};
endmodule

// File: rtl/dual_bank_ram.sv
module dual_bank_ram
    import lane_access_pkg::*;
#(
    parameter  int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  idx,
    input  logic [1:0]        we,
    input  logic [WORD_W-1:0] wdata,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rdata
);
    for (genvar g = 0; g < 2; g++) begin : g_bank
        logic [BYTE_W-1:0] mem [DEPTH];
        logic [BYTE_W-1:0] q;

        always_ff @(posedge clk) begin
            if (we[g]) begin
                mem[idx] <= wdata[g*BYTE_W +: BYTE_W];
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (rd_en) begin
                q <= mem[idx];
            end
        end

        assign rdata[g*BYTE_W +: BYTE_W] = q;
    end
endmodule

// File: rtl/load_align.sv
module load_align
    import lane_access_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  load_ctx_t         ctx,
    output logic [WORD_W-1:0] rd_data,
    output logic [WORD_W-1:0] wb_data
);
    logic [BYTE_W-1:0] pick;

    assign pick = ctx.hi_lane ? word[WORD_W-1:BYTE_W] : word[BYTE_W-1:0];

    always_comb begin
        if (ctx.is_byte) begin
            rd_data = {{BYTE_W{1'b0}}, pick};
            wb_data = widen_byte(pick, ctx.keep_hi, ctx.ext);
        end else begin
            rd_data = word;
            wb_data = word;
        end
    end
endmodule

// File: rtl/lane_access_unit.sv
module lane_access_unit
    import lane_access_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DEPTH_WORDS = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ea,
    input  logic              is_byte,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic              post_inc,
    input  logic [1:0]        ext_mode,
    input  logic [15:0]       wr_data,
    input  logic [15:0]       dst_in,
    output logic [15:0]       rd_data,
    output logic [15:0]       wb_data,
    output logic [1:0]        lane_we,
    output logic [ADDR_W-1:0] ptr_next,
    output logic              addr_trap
);
    localparam int IDX_W = $clog2(DEPTH_WORDS);

    store_req_t        store;
    logic              misalign;
    logic [IDX_W-1:0]  word_idx;
    logic [WORD_W-1:0] ram_q;
    load_ctx_t         ctx_q;
    logic              trap_q;
    logic              unused_ea_hi;
    logic              unused_dst_lo;

    assign word_idx      = ea[IDX_W:1];
    assign unused_ea_hi  = ^ea[ADDR_W-1:IDX_W+1];
    assign unused_dst_lo = ^dst_in[BYTE_W-1:0];

    lane_decode #(.ADDR_W(ADDR_W)) u_decode (
        .ea       (ea),
        .is_byte  (is_byte),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .post_inc (post_inc),
        .wr_data  (wr_data),
        .store    (store),
        .misalign (misalign),
        .ptr_next (ptr_next)
    );

    dual_bank_ram #(.DEPTH(DEPTH_WORDS)) u_ram (
        .clk   (clk),
        .rst   (rst),
        .idx   (word_idx),
        .we    (store.we),
        .wdata (store.lane_data),
        .rd_en (rd_en),
        .rdata (ram_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= '0;
        end else if (rd_en) begin
            ctx_q <= '{is_byte: is_byte,
                       hi_lane: ea[0],
                       ext:     ext_mode_e'(ext_mode),
                       keep_hi: dst_in[WORD_W-1:BYTE_W]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_q <= 1'b0;
        end else begin
            trap_q <= misalign;
        end
    end

    load_align u_align (
        .word    (ram_q),
        .ctx     (ctx_q),
        .rd_data (rd_data),
        .wb_data (wb_data)
    );

    assign lane_we   = store.we;
    assign addr_trap = trap_q;
endmodule

// File: rtl/lane_access_checker.sv
module lane_access_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] ea,
    input logic              is_byte,
    input logic              rd_en,
    input logic              wr_en,
    input logic              post_inc,
    input logic [15:0]       rd_data,
    input logic [1:0]        lane_we,
    input logic [ADDR_W-1:0] ptr_next,
    input logic              addr_trap
);
    p_ptr_step_r1: assert property (@(posedge clk) disable iff (rst)
        (post_inc && (rd_en || wr_en)) |-> ((ptr_next - ea) == (is_byte ? ADDR_W'(1) : ADDR_W'(2))));

    p_ptr_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (!post_inc) |-> (ptr_next == ea));

    p_word_we_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !is_byte && !ea[0]) |-> (lane_we == 2'b11));

    p_byte_we_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && is_byte) |-> ($countones(lane_we) == 1 && lane_we[1] == ea[0]));

    p_no_we_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (!wr_en) |-> (lane_we == 2'b00));

    p_rd_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!rd_en) |=> $stable(rd_data));

    p_byte_rd_hi_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && is_byte) |=> (rd_data[15:8] == 8'h00));

    p_trap_cause_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en || wr_en) && !is_byte && ea[0] |=> addr_trap);

    p_byte_notrap_r8: assert property (@(posedge clk) disable iff (rst)
        ((rd_en || wr_en) && is_byte) |=> !addr_trap);

    p_idle_notrap_r8: assert property (@(posedge clk) disable iff (rst)
        (!rd_en && !wr_en) |=> !addr_trap);

    p_misaligned_nowe_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !is_byte && ea[0]) |-> (lane_we == 2'b00));
endmodule

bind lane_access_unit lane_access_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ea        (ea),
    .is_byte   (is_byte),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .post_inc  (post_inc),
    .rd_data   (rd_data),
    .lane_we   (lane_we),
    .ptr_next  (ptr_next),
    .addr_trap (addr_trap)
);

// File: tb/lane_access_unit_tb.sv
`timescale 1ns/1ps
module lane_access_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] ea;
    logic        is_byte, rd_en, wr_en, post_inc;
    logic [1:0]  ext_mode;
    logic [15:0] wr_data, dst_in;
    logic [15:0] rd_data, wb_data;
    logic [1:0]  lane_we;
    logic [15:0] ptr_next;
    logic        addr_trap;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    lane_access_unit u_dut (
        .clk(clk), .rst(rst), .ea(ea), .is_byte(is_byte), .rd_en(rd_en),
        .wr_en(wr_en), .post_inc(post_inc), .ext_mode(ext_mode),
        .wr_data(wr_data), .dst_in(dst_in), .rd_data(rd_data),
        .wb_data(wb_data), .lane_we(lane_we), .ptr_next(ptr_next),
        .addr_trap(addr_trap)
    );

    // op: 0 idle, 1 load, 2 store
    typedef struct packed {
        logic [1:0]  op;
        logic        byt;
        logic [15:0] ea;
        logic [15:0] wd;
        logic        pi;
        logic [1:0]  ext;
        logic [15:0] dst;
        logic [1:0]  e_we;
        logic [15:0] e_ptr;
        logic        e_trap;
        logic        chk;
        logic [15:0] e_rd;
        logic [15:0] e_wb;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        // R2 word store even address
        '{2'd2, 1'b0, 16'h0008, 16'hA55A, 1'b0, 2'd0, 16'h0000, 2'b11, 16'h0008, 1'b0, 1'b0, 16'h0000, 16'h0000},
        // R3 byte store odd lane, R1 step 1
        '{2'd2, 1'b1, 16'h0009, 16'h0037, 1'b1, 2'd0, 16'h0000, 2'b10, 16'h000A, 1'b0, 1'b0, 16'h0000, 16'h0000},
        // R4 word load, R1 step 2
        '{2'd1, 1'b0, 16'h0008, 16'h0000, 1'b1, 2'd0, 16'h0000, 2'b00, 16'h000A, 1'b0, 1'b1, 16'h375A, 16'h375A},
        // R5 R6 byte load odd lane, merge
        '{2'd1, 1'b1, 16'h0009, 16'h0000, 1'b1, 2'd0, 16'h1234, 2'b00, 16'h000A, 1'b0, 1'b1, 16'h0037, 16'h1237},
        // R7 sign extend, positive byte
        '{2'd1, 1'b1, 16'h0008, 16'h0000, 1'b0, 2'd1, 16'h1234, 2'b00, 16'h0008, 1'b0, 1'b1, 16'h005A, 16'h005A},
        // R2
        '{2'd2, 1'b0, 16'h0010, 16'hC3C3, 1'b0, 2'd0, 16'h0000, 2'b11, 16'h0010, 1'b0, 1'b0, 16'h0000, 16'h0000},
        // R3 even lane, upper data ignored
        '{2'd2, 1'b1, 16'h0010, 16'hAB85, 1'b0, 2'd0, 16'h0000, 2'b01, 16'h0010, 1'b0, 1'b0, 16'h0000, 16'h0000},
        // R7 sign extend, negative byte
        '{2'd1, 1'b1, 16'h0010, 16'h0000, 1'b0, 2'd1, 16'h0000, 2'b00, 16'h0010, 1'b0, 1'b1, 16'h0085, 16'hFF85},
        // R7 zero extend
        '{2'd1, 1'b1, 16'h0010, 16'h0000, 1'b0, 2'd2, 16'hFFFF, 2'b00, 16'h0010, 1'b0, 1'b1, 16'h0085, 16'h0085},
        // R3 other bank untouched, R6 merge
        '{2'd1, 1'b1, 16'h0011, 16'h0000, 1'b1, 2'd0, 16'hFFFF, 2'b00, 16'h0012, 1'b0, 1'b1, 16'h00C3, 16'hFFC3},
        // R10 misaligned store suppressed, R8 trap, R1 still steps
        '{2'd2, 1'b0, 16'h0009, 16'h1111, 1'b1, 2'd0, 16'h0000, 2'b00, 16'h000B, 1'b1, 1'b0, 16'h0000, 16'h0000},
        // R10 RAM unchanged, R8 pulse ended
        '{2'd1, 1'b0, 16'h0008, 16'h0000, 1'b0, 2'd0, 16'h0000, 2'b00, 16'h0008, 1'b0, 1'b1, 16'h375A, 16'h375A},
        // R9 misaligned load completes, R8 trap
        '{2'd1, 1'b0, 16'h0011, 16'h0000, 1'b1, 2'd0, 16'h0000, 2'b00, 16'h0013, 1'b1, 1'b1, 16'hC385, 16'hC385},
        // R8 odd byte load never traps
        '{2'd1, 1'b1, 16'h0011, 16'h0000, 1'b0, 2'd2, 16'h0000, 2'b00, 16'h0011, 1'b0, 1'b1, 16'h00C3, 16'h00C3},
        // R3 odd byte store, no trap
        '{2'd2, 1'b1, 16'h0011, 16'h0066, 1'b1, 2'd0, 16'h0000, 2'b10, 16'h0012, 1'b0, 1'b0, 16'h0000, 16'h0000},
        // R4 word reread
        '{2'd1, 1'b0, 16'h0010, 16'h0000, 1'b1, 2'd0, 16'h0000, 2'b00, 16'h0012, 1'b0, 1'b1, 16'h6685, 16'h6685},
        // R1 idle: no step
        '{2'd0, 1'b0, 16'h0020, 16'h0000, 1'b1, 2'd0, 16'h0000, 2'b00, 16'h0020, 1'b0, 1'b0, 16'h0000, 16'h0000},
        // R6 reserved mode merges
        '{2'd1, 1'b1, 16'h0011, 16'h0000, 1'b0, 2'd3, 16'hABCD, 2'b00, 16'h0011, 1'b0, 1'b1, 16'h0066, 16'hAB66}
    };

    task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        rd_en = 0; wr_en = 0; is_byte = 0; post_inc = 0;
        ext_mode = 2'd0; ea = '0; wr_data = '0; dst_in = '0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] held;
        idle_inputs();
        rst = 1;
        repeat (3) @(posedge clk);
        #2;
        // R11 reset state
        check16("R11 rd_data after reset", rd_data, 16'h0000);
        check16("R11 wb_data after reset", wb_data, 16'h0000);
        check16("R11 addr_trap after reset", {15'd0, addr_trap}, 16'h0000);
        @(negedge clk);
        rst = 0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            rd_en    = (VECS[i].op == 2'd1);
            wr_en    = (VECS[i].op == 2'd2);
            is_byte  = VECS[i].byt;
            ea       = VECS[i].ea;
            wr_data  = VECS[i].wd;
            post_inc = VECS[i].pi;
            ext_mode = VECS[i].ext;
            dst_in   = VECS[i].dst;
            #1;
            check16($sformatf("R2/R3/R10 lane_we vec %0d", i), {14'd0, lane_we}, {14'd0, VECS[i].e_we});
            check16($sformatf("R1 ptr_next vec %0d", i), ptr_next, VECS[i].e_ptr);
            @(posedge clk);
            #2;
            check16($sformatf("R8 addr_trap vec %0d", i), {15'd0, addr_trap}, {15'd0, VECS[i].e_trap});
            if (VECS[i].chk) begin
                check16($sformatf("R4/R5/R9 rd_data vec %0d", i), rd_data, VECS[i].e_rd);
                check16($sformatf("R6/R7 wb_data vec %0d", i), wb_data, VECS[i].e_wb);
            end
        end

        // R4: rd_data holds while no load is requested, even with a store in flight
        held = rd_data;
        @(negedge clk);
        idle_inputs();
        wr_en = 1; ea = 16'h0010; wr_data = 16'h0000;
        @(posedge clk); #2;
        check16("R4 rd_data held during store", rd_data, held);

        // R8: back-to-back misaligned word load, then byte load, pulse ends
        @(negedge clk);
        idle_inputs();
        rd_en = 1; ea = 16'h0021;
        @(posedge clk); #2;
        check16("R8 trap on misaligned load", {15'd0, addr_trap}, 16'h0001);
        @(negedge clk);
        is_byte = 1; ea = 16'h0021;
        @(posedge clk); #2;
        check16("R8 trap clears after byte load", {15'd0, addr_trap}, 16'h0000);

        // R11: reset mid-run clears loaded data and trap
        @(negedge clk);
        idle_inputs();
        rd_en = 1; ea = 16'h0011;
        @(posedge clk); #2;
        check16("R4 reread before reset", rd_data, 16'h0000);
        @(negedge clk);
        rst = 1; idle_inputs(); wr_en = 1; ea = 16'h0009;
        @(posedge clk); #2;
        check16("R11 trap cleared under reset", {15'd0, addr_trap}, 16'h0000);
        check16("R11 rd_data cleared under reset", rd_data, 16'h0000);
        @(negedge clk);
        rst = 0; idle_inputs();
        @(posedge clk); #2;

        finish_run();
    end
endmodule